// File: doc/BRIEF.md
# Multidrop Address-Tagged Character Filter

This block sits between a bit-level serial receiver and the host on a 9-bit multidrop link. Every frame carries one extra tag bit after the data bits. A tag of 1 marks the character as an address and a tag of 0 marks it as data. The tag bit sits in the frame position that would otherwise hold parity, so no parity check takes place. The block watches every character that the deserializer presents, including characters that arrive while the receiver is switched off. It decides which characters enter a small receive FIFO, and it keeps a sticky overrun flag.

When the receiver is enabled, every character is queued. When it is disabled, only address-tagged characters are queued and data-tagged ones are dropped. This lets a station sleep until it hears an address. Each queued entry holds the data bits, the received tag in the status slot normally used for parity error, and the framing-error and break indications as they arrived.

A transmit holding stage is also included. It latches a character together with the tag taken from an address/data mode input at load time.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset, `rd_rdy`, `rd_full`, `ovr_flag` and `tx_vld` are all 0.
- R2: With `rx_en`=1, every strobed character (`rx_vld`=1) is queued whatever its tag, and `rd_rdy` is 1 on the following cycle.
- R3: With `rx_en`=0, a character with `rx_tag`=1 is queued and `rd_rdy` becomes 1 on the following cycle.
- R4: With `rx_en`=0, a character with `rx_tag`=0 is dropped. FIFO occupancy does not change, `rd_rdy` and `rd_full` keep their values, and `ovr_flag` is not set.
- R5: The received tag is stored with its character and is presented on `rd_tag` (1 = address, 0 = data) alongside `rd_data` at the FIFO head.
- R6: The framing-error (`rx_ferr`) and break (`rx_brk`) indications are stored with each queued character and presented on `rd_ferr` and `rd_brk`. This holds whether the receiver is enabled or not.
- R7: A character that would be queued while the FIFO is full and not being popped in the same cycle is lost, the FIFO contents stay unchanged, and `ovr_flag` becomes 1. The flag stays at 1 until `ovr_clr` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R8: Characters leave the FIFO in arrival order. `rd_full` is 1 exactly when DEPTH entries are held. A `rd_pop` pulse removes the head entry.
- R9: A `tx_load` pulse captures `tx_data_in` and takes `tx_tag` from `tx_mode_addr` at that cycle. Later changes of `tx_mode_addr` do not alter the held character. `tx_vld` stays 1 until `tx_take`.
- R10: A `rd_pop` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| rx_vld | input | 1 | One-cycle strobe for a deserialized character |
| rx_data | input | DW | Received data bits |
| rx_tag | input | 1 | Received address/data tag bit |
| rx_ferr | input | 1 | Framing error for this character |
| rx_brk | input | 1 | Break detected with this character |
| rd_pop | input | 1 | Remove the FIFO head entry |
| rd_rdy | output | 1 | FIFO holds at least one character |
| rd_full | output | 1 | FIFO holds DEPTH characters |
| rd_data | output | DW | Head data bits |
| rd_tag | output | 1 | Head tag, held in the parity-error status slot |
| rd_ferr | output | 1 | Head framing-error status |
| rd_brk | output | 1 | Head break status |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clear the overrun flag |
| tx_mode_addr | input | 1 | Tag to attach at load time: 1 = address, 0 = data |
| tx_load | input | 1 | Load the transmit holding stage |
| tx_data_in | input | DW | Character to load |
| tx_take | input | 1 | Downstream transmitter consumes the held character |
| tx_vld | output | 1 | Holding stage is occupied |
| tx_data | output | DW | Held character |
| tx_tag | output | 1 | Tag latched for the held character |

## Verification
The hardest case to reach is a full FIFO meeting a new character while the receiver is disabled. Here a data-tagged character must leave the flag and the contents untouched, while an address-tagged one must raise overrun. The stimulus first fills the queue with enabled characters and then strobes both tag values with the receiver off. Next it drains the queue and checks that exactly the original entries come out, in order. A full sweep over enable, tag, framing and break, across several data patterns, checks what is stored and returned for every combination.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    // Per-character status carried alongside the data bits.
    typedef struct packed {
        logic tag;   // address/data tag, occupies the parity-error slot
        logic ferr;  // framing error
        logic brk;   // break
    } rx_stat_t;

    localparam int STAT_W = $bits(rx_stat_t);

    // A character is kept when the receiver listens, or when it is an address.
    function automatic logic keep_char(input logic en, input logic tag);
        return en | tag;
    endfunction

endpackage

// File: rtl/mdrop_accept.sv
module mdrop_accept (
    input  logic in_vld,
    input  logic en,
    input  logic tag,
    input  logic fifo_full,
    input  logic pop_eff,
    output logic push,
    output logic ovr_evt
);
    import mdrop_pkg::*;

    logic keep;

    always_comb begin
        keep    = in_vld & keep_char(en, tag);
        push    = keep & (~fifo_full | pop_eff);
        ovr_evt = keep & fifo_full & ~pop_eff;
    end
endmodule

// File: rtl/mdrop_fifo.sv
module mdrop_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int OW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [OW-1:0] occ
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_pop;

    assign do_pop = pop & ~empty;
    assign empty  = (occ == '0);
    assign full   = (occ == OW'(DEPTH));
    assign rdata  = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= wdata;
                wptr      <= wptr + 1'b1;
            end
            if (do_pop) rptr <= rptr + 1'b1;
            case ({push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/mdrop_tx_hold.sv
module mdrop_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] ldata,
    input  logic          mode_addr,
    input  logic          take,
    output logic          hvld,
    output logic [DW-1:0] hdata,
    output logic          htag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hvld  <= 1'b0;
            hdata <= '0;
            htag  <= 1'b0;
        end else if (load) begin
            hvld  <= 1'b1;
            hdata <= ldata;
            htag  <= mode_addr;
        end else if (take) begin
            hvld  <= 1'b0;
        end
    end
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_tag,
    input  logic          rx_ferr,
    input  logic          rx_brk,
    input  logic          rd_pop,
    output logic          rd_rdy,
    output logic          rd_full,
    output logic [DW-1:0] rd_data,
    output logic          rd_tag,
    output logic          rd_ferr,
    output logic          rd_brk,
    output logic          ovr_flag,
    input  logic          ovr_clr,
    input  logic          tx_mode_addr,
    input  logic          tx_load,
    input  logic [DW-1:0] tx_data_in,
    input  logic          tx_take,
    output logic          tx_vld,
    output logic [DW-1:0] tx_data,
    output logic          tx_tag
);
    import mdrop_pkg::*;

    localparam int EW = DW + STAT_W;
    localparam int OW = $clog2(DEPTH) + 1;

    rx_stat_t      in_stat, head_stat;
    logic [EW-1:0] wr_word, rd_word;
    logic          push, ovr_evt, empty, pop_eff;
    logic [OW-1:0] occ;

    assign in_stat = '{tag: rx_tag, ferr: rx_ferr, brk: rx_brk};
    assign wr_word = {rx_data, in_stat};
    assign pop_eff = rd_pop & ~empty;

    mdrop_accept u_acc (
        .in_vld   (rx_vld),
        .en       (rx_en),
        .tag      (rx_tag),
        .fifo_full(rd_full),
        .pop_eff  (pop_eff),
        .push     (push),
        .ovr_evt  (ovr_evt)
    );

    mdrop_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .pop  (rd_pop),
        .wdata(wr_word),
        .rdata(rd_word),
        .empty(empty),
        .full (rd_full),
        .occ  (occ)
    );

    assign head_stat = rx_stat_t'(rd_word[STAT_W-1:0]);
    assign rd_data   = rd_word[EW-1:STAT_W];
    assign rd_tag    = head_stat.tag;
    assign rd_ferr   = head_stat.ferr;
    assign rd_brk    = head_stat.brk;
    assign rd_rdy    = ~empty;

    always_ff @(posedge clk) begin
        if (rst)          ovr_flag <= 1'b0;
        else if (ovr_evt) ovr_flag <= 1'b1;
        else if (ovr_clr) ovr_flag <= 1'b0;
    end

    mdrop_tx_hold #(.DW(DW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (tx_load),
        .ldata    (tx_data_in),
        .mode_addr(tx_mode_addr),
        .take     (tx_take),
        .hvld     (tx_vld),
        .hdata    (tx_data),
        .htag     (tx_tag)
    );
endmodule

// File: rtl/mdrop_rx_filter_chk.sv
module mdrop_rx_filter_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int OW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_en,
    input logic          rx_vld,
    input logic          rx_tag,
    input logic          rd_pop,
    input logic          rd_rdy,
    input logic          rd_full,
    input logic          ovr_flag,
    input logic          ovr_clr,
    input logic          tx_load,
    input logic          tx_take,
    input logic          tx_vld,
    input logic [DW-1:0] tx_data,
    input logic          tx_tag,
    input logic [OW-1:0] occ
);
    a_r4_drop_keeps_occ: assert property (@(posedge clk) disable iff (rst)
        rx_vld && !rx_en && !rx_tag && !rd_pop |=> $stable(occ));

    a_r4_drop_no_ovr: assert property (@(posedge clk) disable iff (rst)
        rx_vld && !rx_en && !rx_tag && !ovr_flag |=> !ovr_flag);

    a_r3_tagged_ready: assert property (@(posedge clk) disable iff (rst)
        rx_vld && !rx_en && rx_tag && !rd_full |=> rd_rdy);

    a_r2_enabled_push: assert property (@(posedge clk) disable iff (rst)
        rx_vld && rx_en && !rd_full && !rd_pop |=> occ == $past(occ) + 1'b1);

    a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
        rx_vld && (rx_en || rx_tag) && rd_full && !rd_pop |=> ovr_flag && rd_full);

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        ovr_clr && !rx_vld |=> !ovr_flag);

    a_r8_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(DEPTH));

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        tx_vld && !tx_load && !tx_take |=> tx_vld && $stable(tx_tag) && $stable(tx_data));

    a_r10_pop_empty: assert property (@(posedge clk) disable iff (rst)
        rd_pop && !rd_rdy && !rx_vld |=> !rd_rdy);
endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk #(.DW(DW), .DEPTH(DEPTH), .OW(OW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rx_en   (rx_en),
    .rx_vld  (rx_vld),
    .rx_tag  (rx_tag),
    .rd_pop  (rd_pop),
    .rd_rdy  (rd_rdy),
    .rd_full (rd_full),
    .ovr_flag(ovr_flag),
    .ovr_clr (ovr_clr),
    .tx_load (tx_load),
    .tx_take (tx_take),
    .tx_vld  (tx_vld),
    .tx_data (tx_data),
    .tx_tag  (tx_tag),
    .occ     (occ)
);

// File: tb/mdrop_rx_filter_tb.sv
`timescale 1ns/1ps
module mdrop_rx_filter_tb;
    localparam int DW    = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_en = 0, rx_vld = 0, rx_tag = 0, rx_ferr = 0, rx_brk = 0;
    logic [DW-1:0] rx_data = '0;
    logic          rd_pop = 0, ovr_clr = 0;
    logic          tx_mode_addr = 0, tx_load = 0, tx_take = 0;
    logic [DW-1:0] tx_data_in = '0;
    logic          rd_rdy, rd_full, rd_tag, rd_ferr, rd_brk, ovr_flag, tx_vld, tx_tag;
    logic [DW-1:0] rd_data, tx_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mdrop_rx_filter #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_vld(rx_vld), .rx_data(rx_data),
        .rx_tag(rx_tag), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rd_pop(rd_pop),
        .rd_rdy(rd_rdy), .rd_full(rd_full), .rd_data(rd_data), .rd_tag(rd_tag),
        .rd_ferr(rd_ferr), .rd_brk(rd_brk), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
        .tx_mode_addr(tx_mode_addr), .tx_load(tx_load), .tx_data_in(tx_data_in),
        .tx_take(tx_take), .tx_vld(tx_vld), .tx_data(tx_data), .tx_tag(tx_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic en, input logic tag, input logic fe,
                        input logic bk, input logic [DW-1:0] d);
        @(negedge clk);
        rx_en = en; rx_tag = tag; rx_ferr = fe; rx_brk = bk; rx_data = d; rx_vld = 1;
        @(negedge clk);
        rx_vld = 0;
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_pop = 1;
        @(negedge clk);
        rd_pop = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'h5A; pats[2] = 8'hA5; pats[3] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_rdy", rd_rdy, 0);
        chk("R1", "rd_full", rd_full, 0);
        chk("R1", "ovr_flag", ovr_flag, 0);
        chk("R1", "tx_vld", tx_vld, 0);

        // R10 pop on empty
        pop_one();
        chk("R10", "rd_rdy after empty pop", rd_rdy, 0);
        send(1, 0, 0, 0, 8'h33);
        chk("R10", "head after empty pop", rd_data, 8'h33);
        pop_one();

        // Sweep: enable x tag x framing x break x data pattern (R2..R6)
        for (int i = 0; i < 64; i++) begin
            logic en, tg, fe, bk, keep;
            logic [DW-1:0] d;
            string req;
            en = i[0]; tg = i[1]; fe = i[2]; bk = i[3]; d = pats[i[5:4]];
            keep = en | tg;
            req = en ? "R2" : (tg ? "R3" : "R4");
            send(en, tg, fe, bk, d);
            chk(req, "rd_rdy", rd_rdy, keep);
            chk("R4", "ovr_flag", ovr_flag, 0);
            if (keep) begin
                chk(req, "rd_data", rd_data, d);
                chk("R5", "rd_tag", rd_tag, tg);
                chk("R6", "rd_ferr", rd_ferr, fe);
                chk("R6", "rd_brk", rd_brk, bk);
                pop_one();
                chk("R8", "rd_rdy after pop", rd_rdy, 0);
            end
        end

        // R8 fill and full flag
        for (int k = 0; k < DEPTH; k++) begin
            chk("R8", "rd_full before", rd_full, 0);
            send(1, k[0], 0, 0, 8'h10 + 8'(k));
        end
        chk("R8", "rd_full at depth", rd_full, 1);

        // R4 disabled data char on full FIFO: no overrun, no change
        send(0, 0, 1, 1, 8'hEE);
        chk("R4", "ovr after dropped char on full", ovr_flag, 0);
        chk("R4", "rd_full unchanged", rd_full, 1);
        chk("R4", "head unchanged", rd_data, 8'h10);

        // R7 disabled address char on full FIFO: overrun
        send(0, 1, 0, 0, 8'hAB);
        chk("R7", "ovr after tagged char on full", ovr_flag, 1);
        send(1, 0, 0, 0, 8'hCD);
        chk("R7", "ovr still set", ovr_flag, 1);

        // R8 drain in order; overflowed chars absent
        for (int k = 0; k < DEPTH; k++) begin
            chk("R8", "order data", rd_data, 8'h10 + k);
            chk("R5", "order tag", rd_tag, k % 2);
            pop_one();
        end
        chk("R7", "lost chars not queued", rd_rdy, 0);
        chk("R7", "ovr sticky after drain", ovr_flag, 1);

        @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
        chk("R7", "ovr cleared", ovr_flag, 0);

        // R7 pop and push in the same cycle on a full FIFO: no overrun
        for (int k = 0; k < DEPTH; k++) send(1, 0, 0, 0, 8'h20 + 8'(k));
        @(negedge clk);
        rd_pop = 1; rx_en = 1; rx_tag = 0; rx_data = 8'h99; rx_vld = 1;
        @(negedge clk);
        rd_pop = 0; rx_vld = 0;
        chk("R7", "no ovr with same-cycle pop", ovr_flag, 0);
        chk("R8", "full after swap", rd_full, 1);
        chk("R8", "new head", rd_data, 8'h21);
        for (int k = 0; k < DEPTH; k++) pop_one();
        chk("R8", "empty after drain", rd_rdy, 0);

        // R9 transmit holding stage
        @(negedge clk);
        tx_mode_addr = 1; tx_data_in = 8'h5A; tx_load = 1;
        @(negedge clk);
        tx_load = 0; tx_mode_addr = 0;
        chk("R9", "tx_vld", tx_vld, 1);
        chk("R9", "tx_tag address", tx_tag, 1);
        @(negedge clk);
        chk("R9", "tx_tag after mode change", tx_tag, 1);
        chk("R9", "tx_data", tx_data, 8'h5A);
        tx_take = 1; @(negedge clk); tx_take = 0;
        chk("R9", "tx_vld after take", tx_vld, 0);
        tx_mode_addr = 0; tx_data_in = 8'hC3; tx_load = 1;
        @(negedge clk);
        tx_load = 0; tx_mode_addr = 1;
        @(negedge clk);
        chk("R9", "tx_tag data", tx_tag, 0);
        chk("R9", "tx_data second", tx_data, 8'hC3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule